// File: doc/BRIEF.md
# Vector Element Address Generator

This block turns one 32-bit-element vector memory instruction into a stream of per-element memory requests. A single-cycle `start` pulse loads the command: an addressing mode, a load/store flag, a base address, a byte stride, a packed vector of per-element byte offsets, a per-element enable mask with its override bit, and the requested application vector length. The block then emits one request per handshake. Each request carries the byte address, the element index, the store flag, an active flag and an ordering flag. A downstream memory stage uses these to perform the access. For stores it writes only the active elements. For loads it leaves inactive destination elements untouched and raises no fault for them.

Four addressing modes are supported. Unit-stride and byte-strided addresses come from a running sum. Indexed addresses add a captured per-element offset to the base. Indexed accesses have an ordered and an unordered form, and the ordering flag keeps them distinct downstream. A combinational helper computes the active vector length. It takes the smaller of the requested length and the register-group capacity, which depends on a fixed vector register width, the element width and the group multiplier.

The request port is a valid/ready stream. A request is transferred on a cycle where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, every request field holds its value. `req_valid` never drops until the transfer happens. The block never waits on `req_ready` before raising `req_valid`.

Top module: `vec_agen`

## Requirements
- R1: `vl_out` equals the smaller of `avl` and VLMAX = 128*LMUL/SEW, rounded down. `sew_sel` 0..3 selects SEW = 8, 16, 32, 64. `grp_sel` 0..3 selects LMUL = 1, 2, 4, 8, and 5, 6, 7 select LMUL = 1/8, 1/4, 1/2. `sew_sel` 4..7 and `grp_sel` 4 give VLMAX = 0.
- R2: A `start` is accepted only while `busy` is low. `busy` is high in the cycle after an accepted start. A `start` pulse while busy has no effect on the running sequence.
- R3: In unit-stride mode (`mode` = 0), element i has address base + 4*i.
- R4: In strided mode (`mode` = 1), element i has address base + i*stride. The stride is in bytes, it may be negative, and all address arithmetic wraps modulo 2^32.
- R5: In indexed modes (`mode` = 2 unordered, 3 ordered), element i has address base + offset[i]. offset[i] is `offsets[32*i+31:32*i]`, and the sum wraps modulo 2^32.
- R6: Elements are issued with indices 0, 1, 2, ... in strictly increasing order. `req_ordered` is 1 for every request in mode 3 and 0 for every request in mode 2. Both indexed modes produce the same set of addresses.
- R7: `req_active` is `mask[i]` when `vm` = 0 and 1 when `vm` = 1. `req_store` equals the `is_store` value given with the start.
- R8: The number of requests equals min(vl, 32), with vl taken from R1 at the start. With a count of 0, no request is issued and `done` is high in the cycle after the start.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and all request fields hold. The sequence advances only on a transfer.
- R10: `done` is high for exactly one cycle, the cycle after the last transfer. `busy` is low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle command pulse |
| mode | input | 2 | 0 unit-stride, 1 strided, 2 indexed unordered, 3 indexed ordered |
| is_store | input | 1 | 1 for a store, 0 for a load |
| vm | input | 1 | 1 = every element active, ignore mask |
| avl | input | 32 | Requested application vector length |
| sew_sel | input | 3 | Element-width code for the length helper |
| grp_sel | input | 3 | Register-group multiplier code for the length helper |
| base | input | 32 | Base byte address |
| stride | input | 32 | Byte stride for strided mode |
| offsets | input | 1024 | Packed per-element byte offsets, element 0 in the low word |
| mask | input | 32 | Per-element enable, bit i for element i |
| vl_out | output | 8 | Active vector length from the helper |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | 32 | Element byte address |
| req_idx | output | 5 | Element index |
| req_store | output | 1 | Store flag of the request |
| req_active | output | 1 | Element is enabled |
| req_ordered | output | 1 | Request belongs to an ordered indexed access |

## Verification
`vl_out` is combinational, so it is checked shortly after its inputs settle, in the same cycle. `start` is captured on one rising edge. By the next falling edge `busy` is high and either element 0 is presented or, for a zero count, `done` is high. Each later element appears one cycle after the transfer of the one before it, and `done` follows the last transfer by one cycle. The bench drives `start` and `req_ready` on falling edges and samples every output on the next falling edge. It records the cycle of every transfer and of `done`, so each result is compared at the exact cycle where it is due, including during stalls that it creates with a periodic `req_ready` pattern.

// File: rtl/vec_agen_pkg.sv
`timescale 1ns/1ps
package vec_agen_pkg;

  typedef enum logic [1:0] {
    AM_UNIT      = 2'd0,
    AM_STRIDED   = 2'd1,
    AM_IDX_UNORD = 2'd2,
    AM_IDX_ORD   = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_FIN  = 2'd2
  } sq_state_e;

  typedef struct packed {
    amode_e mode;
    logic   store;
    logic   vm;
  } cmd_t;

endpackage

// File: rtl/vec_agen_vlcalc.sv
`timescale 1ns/1ps
module vec_agen_vlcalc #(
  parameter int VLEN  = 128,
  parameter int AVL_W = 32,
  localparam int VLEN_LOG = $clog2(VLEN),
  localparam int VL_W     = VLEN_LOG + 1
) (
  input  logic [AVL_W-1:0] avl,
  input  logic [2:0]       sew_sel,
  input  logic [2:0]       grp_sel,
  output logic [VL_W-1:0]  vl
);

  logic signed [7:0] grp_log;
  logic signed [7:0] sew_log;
  logic signed [7:0] cap_log;
  logic              grp_ok;
  logic              sew_ok;
  logic [VL_W-1:0]   vlmax;

  always_comb begin
    grp_ok  = 1'b1;
    grp_log = 8'sd0;
    case (grp_sel)
      3'd0:    grp_log = 8'sd0;
      3'd1:    grp_log = 8'sd1;
      3'd2:    grp_log = 8'sd2;
      3'd3:    grp_log = 8'sd3;
      3'd5:    grp_log = -8'sd3;
      3'd6:    grp_log = -8'sd2;
      3'd7:    grp_log = -8'sd1;
      default: grp_ok  = 1'b0;
    endcase
    sew_ok  = (sew_sel <= 3'd3);
    sew_log = 8'sd3 + $signed({5'b0, sew_sel});
    cap_log = $signed(8'(VLEN_LOG)) + grp_log - sew_log;
    if (!grp_ok || !sew_ok || cap_log < 8'sd0) begin
      vlmax = '0;
    end else begin
      vlmax = VL_W'(1) << cap_log[6:0];
    end
    if ({{(AVL_W-VL_W){1'b0}}, vlmax} > avl) begin
      vl = avl[VL_W-1:0];
    end else begin
      vl = vlmax;
    end
  end

endmodule

// File: rtl/vec_agen_seq.sv
`timescale 1ns/1ps
module vec_agen_seq
  import vec_agen_pkg::*;
#(
  parameter int MAX_EL = 32,
  parameter int VL_W   = 8,
  localparam int IDX_W = $clog2(MAX_EL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cmd_t              cmd_in,
  input  logic [MAX_EL-1:0] mask_in,
  input  logic [VL_W-1:0]   vl_in,
  input  logic              req_ready,
  output logic              accept,
  output logic              advance,
  output logic              busy,
  output logic              done,
  output logic              req_valid,
  output logic [IDX_W-1:0]  idx,
  output logic              active,
  output logic              store,
  output logic              ordered,
  output amode_e            mode_q
);

  sq_state_e         state;
  cmd_t              cmd_q;
  logic [MAX_EL-1:0] en_q;
  logic [IDX_W-1:0]  last_q;
  logic [VL_W-1:0]   count;
  logic [MAX_EL-1:0] en_next;

  always_comb begin
    if (vl_in > VL_W'(MAX_EL)) begin
      count = VL_W'(MAX_EL);
    end else begin
      count = vl_in;
    end
  end

  for (genvar g = 0; g < MAX_EL; g++) begin : g_en
    assign en_next[g] = cmd_in.vm | mask_in[g];
  end

  assign accept    = start && (state == SQ_IDLE);
  assign req_valid = (state == SQ_RUN);
  assign advance   = req_valid && req_ready;
  assign busy      = (state != SQ_IDLE);
  assign done      = (state == SQ_FIN);
  assign active    = en_q[idx];
  assign store     = cmd_q.store;
  assign ordered   = (cmd_q.mode == AM_IDX_ORD);
  assign mode_q    = cmd_q.mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      cmd_q  <= '0;
      en_q   <= '0;
      last_q <= '0;
      idx    <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (accept) begin
            cmd_q  <= cmd_in;
            en_q   <= en_next;
            idx    <= '0;
            last_q <= IDX_W'(count - VL_W'(1));
            state  <= (count == '0) ? SQ_FIN : SQ_RUN;
          end
        end
        SQ_RUN: begin
          if (advance) begin
            if (idx == last_q) begin
              state <= SQ_FIN;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vec_agen_addr.sv
`timescale 1ns/1ps
module vec_agen_addr
  import vec_agen_pkg::*;
#(
  parameter int MAX_EL    = 32,
  parameter int AW        = 32,
  parameter int ELEM_BITS = 32,
  localparam int IDX_W      = $clog2(MAX_EL),
  localparam int ELEM_BYTES = ELEM_BITS / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 advance,
  input  amode_e               mode_in,
  input  amode_e               mode_q,
  input  logic [AW-1:0]        base,
  input  logic [AW-1:0]        stride,
  input  logic [MAX_EL*AW-1:0] offsets,
  input  logic [IDX_W-1:0]     idx,
  output logic [AW-1:0]        addr
);

  logic [AW-1:0]             base_q;
  logic [AW-1:0]             step_q;
  logic [AW-1:0]             acc_q;
  logic [MAX_EL-1:0][AW-1:0] off_q;
  logic                      indexed;

  assign indexed = (mode_q == AM_IDX_UNORD) || (mode_q == AM_IDX_ORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      acc_q  <= '0;
      off_q  <= '0;
    end else if (load) begin
      base_q <= base;
      acc_q  <= base;
      step_q <= (mode_in == AM_UNIT) ? AW'(ELEM_BYTES) : stride;
      off_q  <= offsets;
    end else if (advance) begin
      acc_q  <= acc_q + step_q;
    end
  end

  assign addr = indexed ? (base_q + off_q[idx]) : acc_q;

endmodule

// File: rtl/vec_agen.sv
`timescale 1ns/1ps
module vec_agen
  import vec_agen_pkg::*;
#(
  parameter int VLEN      = 128,
  parameter int ELEM_BITS = 32,
  parameter int AW        = 32,
  localparam int MAX_EL = VLEN * 8 / ELEM_BITS,
  localparam int VL_W   = $clog2(VLEN) + 1,
  localparam int IDX_W  = $clog2(MAX_EL)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic                 is_store,
  input  logic                 vm,
  input  logic [31:0]          avl,
  input  logic [2:0]           sew_sel,
  input  logic [2:0]           grp_sel,
  input  logic [AW-1:0]        base,
  input  logic [AW-1:0]        stride,
  input  logic [MAX_EL*AW-1:0] offsets,
  input  logic [MAX_EL-1:0]    mask,
  output logic [VL_W-1:0]      vl_out,
  output logic                 busy,
  output logic                 done,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [AW-1:0]        req_addr,
  output logic [IDX_W-1:0]     req_idx,
  output logic                 req_store,
  output logic                 req_active,
  output logic                 req_ordered
);

  cmd_t   cmd_in;
  amode_e mode_q;
  logic   accept;
  logic   advance;

  assign cmd_in.mode  = amode_e'(mode);
  assign cmd_in.store = is_store;
  assign cmd_in.vm    = vm;

  vec_agen_vlcalc #(.VLEN(VLEN), .AVL_W(32)) u_vlcalc (
    .avl     (avl),
    .sew_sel (sew_sel),
    .grp_sel (grp_sel),
    .vl      (vl_out)
  );

  vec_agen_seq #(.MAX_EL(MAX_EL), .VL_W(VL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_in    (cmd_in),
    .mask_in   (mask),
    .vl_in     (vl_out),
    .req_ready (req_ready),
    .accept    (accept),
    .advance   (advance),
    .busy      (busy),
    .done      (done),
    .req_valid (req_valid),
    .idx       (req_idx),
    .active    (req_active),
    .store     (req_store),
    .ordered   (req_ordered),
    .mode_q    (mode_q)
  );

  vec_agen_addr #(.MAX_EL(MAX_EL), .AW(AW), .ELEM_BITS(ELEM_BITS)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .advance (advance),
    .mode_in (cmd_in.mode),
    .mode_q  (mode_q),
    .base    (base),
    .stride  (stride),
    .offsets (offsets),
    .idx     (req_idx),
    .addr    (req_addr)
  );

endmodule

// File: rtl/vec_agen_chk.sv
`timescale 1ns/1ps
module vec_agen_chk #(
  parameter int VL_W  = 8,
  parameter int IDX_W = 5,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      avl,
  input logic [VL_W-1:0]  vl_out,
  input logic             busy,
  input logic             done,
  input logic             req_valid,
  input logic             req_ready,
  input logic [AW-1:0]    req_addr,
  input logic [IDX_W-1:0] req_idx,
  input logic             req_active
);

  AST_VL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    {{(32-VL_W){1'b0}}, vl_out} <= avl); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R2

  AST_FIRST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (req_valid ? (req_idx == '0) : done)); // R8

  AST_IDX_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_valid || (req_idx == $past(req_idx) + 1'b1))); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_idx) && $stable(req_active))); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !req_valid)); // R10

endmodule

bind vec_agen vec_agen_chk #(.VL_W(VL_W), .IDX_W(IDX_W), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .avl        (avl),
  .vl_out     (vl_out),
  .busy       (busy),
  .done       (done),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_idx    (req_idx),
  .req_active (req_active)
);

// File: tb/vec_agen_bench.sv
`timescale 1ns/1ps
module vec_agen_bench;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          is_store = 1'b0;
  logic          vm = 1'b1;
  logic [31:0]   avl = '0;
  logic [2:0]    sew_sel = 3'd2;
  logic [2:0]    grp_sel = 3'd0;
  logic [31:0]   base = '0;
  logic [31:0]   stride = '0;
  logic [1023:0] offsets = '0;
  logic [31:0]   mask = '0;
  logic          req_ready = 1'b1;
  logic [7:0]    vl_out;
  logic          busy, done, req_valid, req_store, req_active, req_ordered;
  logic [31:0]   req_addr;
  logic [4:0]    req_idx;

  int total = 0;
  int bad = 0;

  logic [31:0] r_addr [0:63];
  int          r_idx  [0:63];
  bit          r_act  [0:63];
  bit          r_st   [0:63];
  bit          r_ord  [0:63];
  int          n_rec, done_at, last_hs;
  bit          busy0;

  always #10 clk = ~clk;

  vec_agen u_vec_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .is_store(is_store),
    .vm(vm), .avl(avl), .sew_sel(sew_sel), .grp_sel(grp_sel), .base(base),
    .stride(stride), .offsets(offsets), .mask(mask), .vl_out(vl_out),
    .busy(busy), .done(done), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_idx(req_idx), .req_store(req_store),
    .req_active(req_active), .req_ordered(req_ordered)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_vl(input int a, input int s, input int g);
    int bits, num, den, cap;
    bits = (s <= 3) ? (8 << s) : 0;
    num = 1; den = 1;
    case (g)
      0: num = 1;  1: num = 2;  2: num = 4;  3: num = 8;
      5: den = 8;  6: den = 4;  7: den = 2;
      default: num = 0;
    endcase
    cap = (bits == 0) ? 0 : (128 * num) / (den * bits);
    return (a < cap) ? a : cap;
  endfunction

  task automatic launch(input logic [1:0] m, input bit st, input bit v, input int a,
                        input int s, input int g, input logic [31:0] b, input logic [31:0] sd);
    @(negedge clk);
    mode = m; is_store = st; vm = v; avl = a; sew_sel = 3'(s); grp_sel = 3'(g);
    base = b; stride = sd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic collect(input int stall);
    bit pv, pr;
    logic [31:0] pa;
    logic [4:0]  pi;
    n_rec = 0; done_at = -1; last_hs = -1; pv = 0; pr = 0; pa = '0; pi = '0;
    for (int c = 0; c < 300; c++) begin
      req_ready = (stall == 0) || ((c % stall) != (stall - 1));
      #1;
      if (c == 0) busy0 = busy;
      if (pv && !pr) begin
        chk("R9 valid held", {31'b0, req_valid}, 32'd1);
        chk("R9 addr held", req_addr, pa);
        chk("R9 idx held", {27'b0, req_idx}, {27'b0, pi});
      end
      if (done) begin
        done_at = c;
        break;
      end
      if (req_valid && req_ready) begin
        r_addr[n_rec] = req_addr; r_idx[n_rec] = req_idx; r_act[n_rec] = req_active;
        r_st[n_rec] = req_store; r_ord[n_rec] = req_ordered;
        n_rec++;
        last_hs = c;
      end
      pv = req_valid; pr = req_ready; pa = req_addr; pi = req_idx;
      @(negedge clk);
    end
    req_ready = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 busy low after done", {31'b0, busy}, 32'd0);
  endtask

  task automatic close_run(input int nexp);
    chk("R8 request count", n_rec, nexp);
    if (nexp > 0) chk("R10 done after last transfer", done_at, last_hs + 1);
    else          chk("R8 zero count done timing", done_at, 0);
  endtask

  task automatic t_reset();
    chk("R2 reset busy", {31'b0, busy}, 32'd0);
    chk("R10 reset done", {31'b0, done}, 32'd0);
    chk("R9 reset valid", {31'b0, req_valid}, 32'd0);
  endtask

  task automatic t_length();
    int cases [0:6][0:2] = '{'{100,2,0}, '{3,2,0}, '{1000,0,3}, '{9,3,5},
                             '{50,2,4}, '{5,2,6}, '{70,5,2}};
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      avl = cases[k][0]; sew_sel = 3'(cases[k][1]); grp_sel = 3'(cases[k][2]);
      #1;
      chk("R1 vl", {24'b0, vl_out}, exp_vl(cases[k][0], cases[k][1], cases[k][2]));
    end
  endtask

  task automatic t_unit();
    mask = '0;
    launch(2'd0, 1'b0, 1'b1, 5, 2, 1, 32'h0000_1000, 32'h0);
    collect(0);
    chk("R2 busy after start", {31'b0, busy0}, 32'd1);
    close_run(5);
    for (int i = 0; i < n_rec; i++) begin
      chk("R3 unit addr", r_addr[i], 32'h1000 + 4 * i);
      chk("R6 unit idx", r_idx[i], i);
      chk("R7 vm forces active", {31'b0, r_act[i]}, 32'd1);
      chk("R7 load flag", {31'b0, r_st[i]}, 32'd0);
    end
  endtask

  task automatic t_strided_wrap();
    mask = 32'h0000_005A;
    launch(2'd1, 1'b1, 1'b0, 7, 2, 1, 32'hFFFF_FF80, 32'h40);
    collect(3);
    close_run(7);
    for (int i = 0; i < n_rec; i++) begin
      chk("R4 strided wrap addr", r_addr[i], 32'hFFFF_FF80 + 32'(i) * 32'h40);
      chk("R7 mask active", {31'b0, r_act[i]}, {31'b0, mask[i]});
      chk("R7 store flag", {31'b0, r_st[i]}, 32'd1);
    end
  endtask

  task automatic t_strided_neg();
    launch(2'd1, 1'b0, 1'b1, 3, 2, 0, 32'h0000_2000, 32'hFFFF_FFF4);
    collect(2);
    close_run(3);
    for (int i = 0; i < n_rec; i++)
      chk("R4 negative stride addr", r_addr[i], 32'h2000 - 32'(12 * i));
  endtask

  function automatic logic [31:0] off_of(input int i);
    return (i == 3) ? 32'hFFFF_FFFC : ((32'(i) * 32'd52) ^ 32'h30);
  endfunction

  task automatic t_indexed_ordered();
    for (int i = 0; i < 32; i++) offsets[32*i +: 32] = off_of(i);
    launch(2'd3, 1'b0, 1'b1, 9, 2, 2, 32'h8000_0000, 32'h0);
    collect(0);
    close_run(9);
    for (int i = 0; i < n_rec; i++) begin
      chk("R5 indexed addr", r_addr[i], 32'h8000_0000 + off_of(i));
      chk("R6 ordered idx", r_idx[i], i);
      chk("R6 ordered flag", {31'b0, r_ord[i]}, 32'd1);
    end
  endtask

  task automatic t_indexed_unordered();
    launch(2'd2, 1'b1, 1'b1, 6, 2, 1, 32'h0000_0004, 32'h0);
    collect(2);
    close_run(6);
    for (int i = 0; i < 6; i++) begin
      bit found = 0;
      for (int k = 0; k < n_rec; k++)
        if (r_addr[k] == 32'h4 + off_of(i)) found = 1;
      chk("R6 unordered address set", {31'b0, found}, 32'd1);
    end
    for (int k = 0; k < n_rec; k++)
      chk("R6 unordered flag", {31'b0, r_ord[k]}, 32'd0);
  endtask

  task automatic t_zero();
    launch(2'd0, 1'b0, 1'b1, 0, 2, 0, 32'h0, 32'h0);
    collect(0);
    close_run(0);
  endtask

  task automatic t_clamp();
    launch(2'd0, 1'b0, 1'b1, 200, 0, 3, 32'h0000_0040, 32'h0);
    #1;
    chk("R1 vl at capacity", {24'b0, vl_out}, 32'd128);
    collect(0);
    close_run(32);
    chk("R8 last clamped addr", r_addr[31], 32'h40 + 31 * 4);
  endtask

  task automatic t_start_while_busy();
    launch(2'd0, 1'b0, 1'b1, 3, 2, 0, 32'h0000_0100, 32'h0);
    req_ready = 1'b0;
    mode = 2'd1; base = 32'h0000_0900; stride = 32'h8; avl = 20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    collect(0);
    close_run(3);
    for (int i = 0; i < n_rec; i++)
      chk("R2 start ignored while busy", r_addr[i], 32'h100 + 4 * i);
    @(negedge clk);
    #1;
    chk("R2 no second sequence", {31'b0, req_valid}, 32'd0);
  endtask

  initial begin
    #3000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_length();
    t_unit();
    t_strided_wrap();
    t_strided_neg();
    t_indexed_ordered();
    t_indexed_unordered();
    t_zero();
    t_clamp();
    t_start_while_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule